// File: doc/BRIEF.md
# Carry-Free Signed-Digit Decimal Adder

This block adds or subtracts two radix-10 numbers held in signed-digit form. Each digit is a small two's-complement field that may be negative, so a number needs no separate sign. Every digit position works out its own transfer digit from its two operand digits alone. It then takes in the single transfer handed over by the neighbour on its right. Because of this, the time to settle does not grow with the number of digits, and no carry has to ripple across the word.

The operands come in as packed digit vectors, plus a subtract control that negates each digit of the second operand. The result is captured in one output register stage. That stage holds the sum digits, the transfer that leaves the top position (reported as an overflow digit, not thrown away), and a flag that gives the sign of the whole result. The most negative bit pattern of a digit field is never a legal value. When it shows up on an input, it acts as a marker that is carried through to the result.

Top module: `sd_adder`

## Requirements
- R1: While reset is low, every sum digit reads 0, the overflow output reads 00 and the sign flag reads 0.
- R2: One clock after the operands are applied, the result value equals x+y when subtract is 0 and x-y when subtract is 1. The result value is the sum of each result digit times 10^i, plus the overflow digit times 10^NDIG.
- R3: Digit i sits in bits [5i+4:5i] as 5-bit two's complement. With s = x_i + y_i (or x_i - y_i when subtracting), the transfer leaving position i is +1 when s >= 9, -1 when s <= -9 and 0 otherwise. The interim digit is s - 10·transfer. The result digit is that interim digit plus the transfer leaving position i-1, with 0 coming into position 0.
- R4: When no input digit holds the reserved pattern, every result digit lies between -9 and +9.
- R5: The overflow output is the transfer leaving the top position, coded in 2-bit two's complement: 01 for +1, 11 for -1, 00 for 0. The code 10 never appears.
- R6: The sign flag is 1 exactly when the result value is negative. That sign is set by the most significant non-zero digit, with the overflow digit counted first. A zero result gives 0.
- R7: Changing the operand digits at position k alone changes at most result digits k and k+1, and the overflow output only when k is the top position.
- R8: If any digit of either operand holds the reserved pattern 10000 (-16), then one clock later every result digit is 10000, overflow is 00 and the sign flag is 0. This holds for both add and subtract.
- R9: The outputs change only on the rising clock edge, one cycle after the inputs they reflect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_in | input | NDIG*DW | First operand digits, digit i at bits [DW*i+DW-1:DW*i] |
| y_in | input | NDIG*DW | Second operand digits, same layout |
| sub_in | input | 1 | 1 selects x - y, 0 selects x + y |
| sum_out | output | NDIG*DW | Registered result digits |
| ovf_out | output | 2 | Registered transfer leaving the top position |
| neg_out | output | 1 | Registered sign of the full result |

## Verification
Two functions can decide the result in the same cycle: the overflow transfer out of the top position, and the sign flag. These collide when the top operand digits push the transfer one way while the lower digits point the other way. The bench sets this up on purpose, for example with top digits of -9 and -9 and positive lower digits. The sign is then judged from the whole integer value, overflow digit included, not from the top result digit. A second collision pairs the reserved marker with subtraction, since negating the marker must not hide it. Random add and subtract vectors are also compared against an integer reference model on every clock.

// File: rtl/sd_adder.sv
`timescale 1ns/1ps
module sd_adder #(
  parameter int NDIG  = 8,
  parameter int DW    = 5,
  parameter int RADIX = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NDIG*DW-1:0]  x_in,
  input  logic [NDIG*DW-1:0]  y_in,
  input  logic                sub_in,
  output logic [NDIG*DW-1:0]  sum_out,
  output logic [1:0]          ovf_out,
  output logic                neg_out
);
  localparam int TW = NDIG*DW;
  localparam logic signed [DW:0]   RAD_S = (DW+1)'(RADIX);
  localparam logic signed [DW:0]   LIM_S = (DW+1)'(RADIX-1);
  localparam logic signed [DW-1:0] MARK  = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW:0]   ps [NDIG];
  logic signed [DW:0]   iu [NDIG];
  logic signed [1:0]    tr [NDIG];
  logic signed [DW-1:0] sd [NDIG];
  logic [NDIG-1:0]      mark_hit;
  logic                 any_mark;
  logic                 neg_c, found;
  logic [TW-1:0]        sum_c;

  genvar i;
  generate
    for (i = 0; i < NDIG; i++) begin : g_dig
      logic signed [DW-1:0] xd, yd, ye;
      logic signed [1:0]    tin;
      assign xd = x_in[i*DW +: DW];
      assign yd = y_in[i*DW +: DW];
      assign ye = sub_in ? -yd : yd;
      assign mark_hit[i] = (xd == MARK) || (yd == MARK);
      assign ps[i] = {xd[DW-1], xd} + {ye[DW-1], ye};
      assign tr[i] = (ps[i] >= LIM_S) ? 2'sb01 : ((ps[i] <= -LIM_S) ? 2'sb11 : 2'sb00);
      assign iu[i] = (tr[i] == 2'sb01) ? ps[i] - RAD_S :
                     (tr[i] == 2'sb11) ? ps[i] + RAD_S : ps[i];
      if (i == 0) begin : g_lo
        assign tin = 2'sb00;
      end else begin : g_hi
        assign tin = tr[i-1];
      end
      assign sd[i] = DW'(iu[i] + {{(DW-1){tin[1]}}, tin});
      assign sum_c[i*DW +: DW] = sd[i];

      a_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !any_mark |=> ($signed(sum_out[i*DW +: DW]) <= $signed(LIM_S[DW-1:0]) &&
                       $signed(sum_out[i*DW +: DW]) >= -$signed(LIM_S[DW-1:0])));
    end
  endgenerate

  assign any_mark = |mark_hit;

  always_comb begin
    neg_c = 1'b0;
    found = 1'b0;
    if (tr[NDIG-1] != 2'sb00) begin
      neg_c = tr[NDIG-1][1];
      found = 1'b1;
    end
    for (int k = NDIG-1; k >= 0; k--) begin
      if (!found && sd[k] != '0) begin
        neg_c = sd[k][DW-1];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_out <= '0;
      ovf_out <= 2'b00;
      neg_out <= 1'b0;
    end else if (any_mark) begin
      sum_out <= {NDIG{MARK}};
      ovf_out <= 2'b00;
      neg_out <= 1'b0;
    end else begin
      sum_out <= sum_c;
      ovf_out <= tr[NDIG-1];
      neg_out <= neg_c;
    end
  end

  a_marker_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_mark |=> (sum_out == {NDIG{MARK}} && ovf_out == 2'b00 && !neg_out));

  a_top_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_mark && ps[NDIG-1] >= LIM_S) |=> (ovf_out == 2'b01));

  a_top_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_mark && ps[NDIG-1] <= -LIM_S) |=> (ovf_out == 2'b11));

  a_ovf_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_out != 2'b10);

  a_sign_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_out == 2'b01) |-> !neg_out);

  a_sign_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_out == 2'b11) |-> neg_out);

  a_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_out == '0 && ovf_out == 2'b00) |-> !neg_out);
endmodule

// File: tb/sd_adder_test.sv
`timescale 1ns/1ps
module sd_adder_test;
  localparam int N  = 8;
  localparam int W  = 5;
  localparam int TW = N*W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] xv = '0, yv = '0;
  logic sub = 1'b0;
  wire  [TW-1:0] sv;
  wire  [1:0] ov;
  wire  ng;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [TW-1:0] last_sv;
  logic [1:0] last_ov;

  sd_adder #(.NDIG(N), .DW(W), .RADIX(10)) uut (
    .clk(clk), .rst_n(rst_n), .x_in(xv), .y_in(yv), .sub_in(sub),
    .sum_out(sv), .ovf_out(ov), .neg_out(ng));

  always #2 clk = ~clk;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dig(logic [TW-1:0] v, int i);
    logic signed [W-1:0] f;
    f = v[i*W +: W];
    return int'(f);
  endfunction

  function automatic logic [TW-1:0] pack(int d[N]);
    logic [TW-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++) v[i*W +: W] = d[i][W-1:0];
    return v;
  endfunction

  task automatic apply(int xa[N], int ya[N], bit s);
    int ta[N], ua[N];
    longint p, vref, vact;
    int ovi;
    @(negedge clk);
    xv = pack(xa); yv = pack(ya); sub = s;
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) begin
      int ss;
      ss = xa[i] + (s ? -ya[i] : ya[i]);
      ta[i] = (ss >= 9) ? 1 : ((ss <= -9) ? -1 : 0);
      ua[i] = ss - 10*ta[i];
    end
    p = 1; vref = 0; vact = 0;
    for (int i = 0; i < N; i++) begin
      int e;
      e = ua[i] + ((i > 0) ? ta[i-1] : 0);
      chk(dig(sv, i) == e, "R3 digit", dig(sv, i), e);
      chk(dig(sv, i) <= 9 && dig(sv, i) >= -9, "R4 range", dig(sv, i), 0);
      vref += p * (xa[i] + (s ? -ya[i] : ya[i]));
      vact += p * dig(sv, i);
      p *= 10;
    end
    ovi = (ov == 2'b01) ? 1 : ((ov == 2'b11) ? -1 : ((ov == 2'b00) ? 0 : 99));
    vact += p * ovi;
    chk(ovi == ta[N-1], "R5 overflow", ovi, ta[N-1]);
    chk(vact == vref, "R2 value", vact, vref);
    chk(ng == (vref < 0), "R6 sign", ng, (vref < 0));
    last_sv = sv; last_ov = ov;
  endtask

  task automatic apply_mark(int xa[N], int ya[N], bit s);
    @(negedge clk);
    xv = pack(xa); yv = pack(ya); sub = s;
    @(posedge clk); #1;
    for (int i = 0; i < N; i++)
      chk(dig(sv, i) == -16, "R8 marker digit", dig(sv, i), -16);
    chk(ov == 2'b00, "R8 marker overflow", ov, 0);
    chk(ng == 1'b0, "R8 marker sign", ng, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    int xa[N], ya[N];
    repeat (3) @(posedge clk);
    #1;
    chk(sv == '0, "R1 reset digits", sv, 0);
    chk(ov == 2'b00, "R1 reset overflow", ov, 0);
    chk(ng == 1'b0, "R1 reset sign", ng, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 R5: all nines -> every position transfers +1
    for (int i = 0; i < N; i++) begin xa[i] = 9; ya[i] = 9; end
    apply(xa, ya, 0);
    for (int i = 0; i < N; i++) begin xa[i] = -9; ya[i] = -9; end
    apply(xa, ya, 0);
    // R6: equal operands subtracted give zero, sign 0
    for (int i = 0; i < N; i++) begin xa[i] = i - 4; ya[i] = i - 4; end
    apply(xa, ya, 1);
    chk(sv == '0, "R6 zero digits", sv, 0);
    // R6 R5: top transfer -1 against positive lower digits
    for (int i = 0; i < N; i++) begin xa[i] = 5; ya[i] = 3; end
    xa[N-1] = -9; ya[N-1] = -9;
    apply(xa, ya, 0);
    chk(ng == 1'b1, "R6 transfer sign", ng, 1);
    // R6: top digit zero, sign from lower digit
    for (int i = 0; i < N; i++) begin xa[i] = 0; ya[i] = 0; end
    xa[2] = -3; xa[0] = 7;
    apply(xa, ya, 0);
    // thresholds exactly at 8/9
    for (int i = 0; i < N; i++) begin xa[i] = 4; ya[i] = (i % 2) ? 5 : 4; end
    apply(xa, ya, 0);
    apply(xa, ya, 1);

    // R8: marker in x during add, in y during subtract
    for (int i = 0; i < N; i++) begin xa[i] = 1; ya[i] = 2; end
    xa[3] = -16;
    apply_mark(xa, ya, 0);
    xa[3] = 1; ya[N-1] = -16;
    apply_mark(xa, ya, 1);

    // R7: change one position, others stay
    for (int r = 0; r < 40; r++) begin
      logic [TW-1:0] ref_sv;
      logic [1:0] ref_ov;
      int k;
      bit s;
      s = 1'($urandom_range(1));
      for (int i = 0; i < N; i++) begin
        xa[i] = int'($urandom_range(18)) - 9;
        ya[i] = int'($urandom_range(18)) - 9;
      end
      apply(xa, ya, s);
      ref_sv = last_sv; ref_ov = last_ov;
      k = int'($urandom_range(N-1));
      xa[k] = int'($urandom_range(18)) - 9;
      ya[k] = int'($urandom_range(18)) - 9;
      apply(xa, ya, s);
      for (int i = 0; i < N; i++)
        if (i != k && i != k+1)
          chk(dig(last_sv, i) == dig(ref_sv, i), "R7 locality", dig(last_sv, i), dig(ref_sv, i));
      if (k != N-1)
        chk(last_ov == ref_ov, "R7 overflow locality", last_ov, ref_ov);
    end

    // R2 R9: random add/subtract stream, checked every clock
    for (int r = 0; r < 400; r++) begin
      for (int i = 0; i < N; i++) begin
        xa[i] = int'($urandom_range(18)) - 9;
        ya[i] = int'($urandom_range(18)) - 9;
      end
      apply(xa, ya, 1'($urandom_range(1)));
    end

    // R9: output holds between edges
    @(negedge clk);
    last_sv = sv;
    #1;
    chk(sv == last_sv, "R9 stable between edges", sv, last_sv);
    summary();
  end
endmodule